// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block receives stereo PCM audio from a three-wire serial link (bit clock, word select, data) and turns it into parallel 16-bit left and right samples. It is a slave. The external bit clock, word select and data each pass through a two-flop synchronizer into a faster system clock. The rising edge of the bit clock is then found in the system clock domain. The system clock must run at least four times faster than the bit clock.

A static two-bit mode input selects the framing. The framings differ in how far the MSB sits from the word-select transition and in which word-select level marks the left channel. A bit position counter restarts at each word-select change. Only the 16 positions of the selected mode's window are shifted in. When a right word completes a frame whose left word was captured, both samples appear together with a one-cycle strobe.

Top module: `pcm_frame_rx`

## Requirements
- R1: While reset is low, and in the first cycle after reset rises, `valid_o` is 0 and `left_o` and `right_o` are 0.
- R2: Data is taken only at bit-clock rising edges, MSB first, as 16 consecutive bits forming bit 15 down to bit 0. Position 0 of a word is the first bit-clock rising edge at which a new word-select level is seen. Each later rising edge adds one to the position.
- R3: With `mode_i` = 2 or 3 (left-justified), the MSB is at position 0 and word select high marks the left channel.
- R4: With `mode_i` = 1 (I2S-style), the MSB is at position 1 and word select low marks the left channel.
- R5: With `mode_i` = 0 (right-justified), the MSB is at position 16 and word select high marks the left channel. With 32 bit clocks per channel, the LSB is at the last position before the next transition.
- R6: Bits at positions outside the mode's 16-bit window have no effect on the output samples.
- R7: When a right word completes after a left word of the same frame, `left_o` and `right_o` update together and `valid_o` is high for exactly one system cycle. At all other times the outputs hold their values.
- R8: A new `mode_i` value takes effect only at a word-select change that starts a left word under the new value. The word already in progress, and a right word that starts after the change, are decoded in the old mode.
- R9: A left word captured before a mode switch is discarded. No strobe is produced for that incomplete frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Framing: 0 right-justified, 1 I2S-style, 2/3 left-justified |
| bclk_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select |
| sd_i | input | 1 | External serial data |
| left_o | output | 16 | Last complete left sample |
| right_o | output | 16 | Last complete right sample |
| valid_o | output | 1 | One-cycle strobe when a new sample pair is presented |

## Verification
Each framing is driven with walking-one left samples paired with walking-zero right samples, plus all-zero, all-one, MSB-only, LSB-only and alternating words. A shifted window, a bit-order reversal or swapped channels each produce a visibly wrong pair. Positions outside the window carry a non-zero filler that depends on the sample, so a window that is too wide or misplaced corrupts the result. Two mode switches are tried. In the first, the polarity stays the same and the switch falls within a frame, so the frame must decode in the old mode. In the second, the polarity flips, so a stranded left word must be dropped and produce no strobe.

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx #(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                bclk_i,
  input  logic                ws_i,
  input  logic                sd_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int CW = $clog2(SLOT_BITS) + 1;
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] RJ_DELAY = CW'(SLOT_BITS - SAMPLE_W);

  function automatic logic is_left(input logic [1:0] m, input logic w);
    return (m == 2'd1) ? ~w : w;
  endfunction

  logic [1:0] bclk_sy, ws_sy, sd_sy;
  logic       bclk_q, armed_q, ws_prev_q, chan_left_q, left_done_q;
  logic [1:0] mode_q;
  logic [CW-1:0] cnt_q;
  logic [SAMPLE_W-1:0] shreg_q, left_hold_q;

  wire bclk_s = bclk_sy[1];
  wire ws_s   = ws_sy[1];
  wire sd_s   = sd_sy[1];

  wire rise_w    = bclk_s & ~bclk_q;
  wire ws_edge_w = rise_w & armed_q & (ws_s ^ ws_prev_q);

  wire [1:0] mode_nxt  = is_left(mode_i, ws_s) ? mode_i : mode_q;
  wire       new_left  = is_left(mode_nxt, ws_s);
  wire [1:0] mode_use  = ws_edge_w ? mode_nxt : mode_q;
  wire       left_use  = ws_edge_w ? new_left : chan_left_q;

  logic [CW-1:0] pos, delay;
  always_comb begin
    if (ws_edge_w)           pos = '0;
    else if (cnt_q == CNT_MAX) pos = CNT_MAX;
    else                     pos = cnt_q + 1'b1;
    case (mode_use)
      2'd0:    delay = RJ_DELAY;
      2'd1:    delay = CW'(1);
      default: delay = '0;
    endcase
  end

  wire in_win = (pos >= delay) && (pos < delay + CW'(SAMPLE_W));
  wire last   = (pos == delay + CW'(SAMPLE_W - 1));
  wire [SAMPLE_W-1:0] word = {shreg_q[SAMPLE_W-2:0], sd_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sy <= '0;
      ws_sy   <= '0;
      sd_sy   <= '0;
      bclk_q  <= 1'b0;
    end else begin
      bclk_sy <= {bclk_sy[0], bclk_i};
      ws_sy   <= {ws_sy[0], ws_i};
      sd_sy   <= {sd_sy[0], sd_i};
      bclk_q  <= bclk_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      ws_prev_q   <= 1'b0;
      chan_left_q <= 1'b0;
      left_done_q <= 1'b0;
      mode_q      <= 2'd0;
      cnt_q       <= CNT_MAX;
      shreg_q     <= '0;
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_w) begin
        armed_q   <= 1'b1;
        ws_prev_q <= ws_s;
        cnt_q     <= pos;
        if (ws_edge_w) begin
          mode_q      <= mode_nxt;
          chan_left_q <= new_left;
          if (new_left) left_done_q <= 1'b0;
        end
        if (in_win) shreg_q <= word;
        if (in_win && last) begin
          if (left_use) begin
            left_hold_q <= word;
            left_done_q <= 1'b1;
          end else if (left_done_q && !(ws_edge_w && new_left)) begin
            left_o      <= left_hold_q;
            right_o     <= word;
            valid_o     <= 1'b1;
            left_done_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_frame_rx_chk.sv
module pcm_frame_rx_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                rise_w,
  input logic                ws_edge_w,
  input logic [1:0]          mode_q
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!valid_o && left_o == '0 && right_o == '0));

  assert_strobe_on_bit_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(rise_w));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_mode_at_ws_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(ws_edge_w));
endmodule

bind pcm_frame_rx pcm_frame_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_o(valid_o), .left_o(left_o), .right_o(right_o),
  .rise_w(rise_w), .ws_edge_w(ws_edge_w), .mode_q(mode_q)
);

// File: tb/test_pcm_frame_rx.sv
module test_pcm_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        bclk_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic [15:0] left_o, right_o;
  logic        valid_o;

  pcm_frame_rx i_pcm_frame_rx (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bclk_i(bclk_i), .ws_i(ws_i),
    .sd_i(sd_i), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, n_exp = 0, n_got = 0;
  logic [15:0] exp_l [0:255];
  logic [15:0] exp_r [0:255];
  string       exp_tag [0:255];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (n_got < n_exp) begin
        check({exp_tag[n_got], " R2 R6 R7 pair"}, {left_o, right_o}, {exp_l[n_got], exp_r[n_got]});
      end else begin
        check("R9 unexpected strobe", {left_o, right_o}, 32'hFFFF_FFFF);
        check("R9 strobe count", n_got + 1, n_exp);
      end
      n_got++;
    end
  end

  function automatic logic bit_for(input logic [1:0] m, input int p, input logic [15:0] s);
    int d;
    d = (m == 2'd0) ? 16 : (m == 2'd1) ? 1 : 0;
    if (p >= d && p < d + 16) return s[15 - (p - d)];
    return ~s[p % 16] ^ p[0];
  endfunction

  task automatic bit_out(input logic w, input logic d);
    @(negedge clk);
    bclk_i = 1'b0; ws_i = w; sd_i = d;
    repeat (3) @(negedge clk);
    bclk_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(input logic [1:0] m, input logic w, input logic [15:0] s);
    for (int p = 0; p < 32; p++) bit_out(w, bit_for(m, p, s));
  endtask

  function automatic logic left_lvl(input logic [1:0] m);
    return (m == 2'd1) ? 1'b0 : 1'b1;
  endfunction

  task automatic prime(input logic [1:0] m);
    for (int i = 0; i < 4; i++) bit_out(~left_lvl(m), 1'b1);
  endtask

  task automatic expect_pair(input string tag, input logic [15:0] l, input logic [15:0] r);
    exp_l[n_exp] = l; exp_r[n_exp] = r; exp_tag[n_exp] = tag; n_exp++;
  endtask

  task automatic send_frame(input logic [1:0] m, input logic [15:0] l,
                            input logic [15:0] r, input string tag);
    send_slot(m, left_lvl(m), l);
    if (n_got > 0)
      check("R7 outputs hold between strobes", {left_o, right_o},
            {exp_l[n_got-1], exp_r[n_got-1]});
    expect_pair(tag, l, r);
    send_slot(m, ~left_lvl(m), r);
  endtask

  task automatic sweep(input logic [1:0] m, input string tag);
    mode_i = m;
    prime(m);
    for (int i = 0; i < 16; i++) send_frame(m, 16'(1 << i), ~16'(1 << i), tag);
    send_frame(m, 16'h0000, 16'hFFFF, tag);
    send_frame(m, 16'h8000, 16'h0001, tag);
    send_frame(m, 16'hA5A5, 16'h5A5A, tag);
    send_frame(m, 16'hFFFF, 16'h0000, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d strobes", n_got, n_exp);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset valid", valid_o, 0);
    check("R1 reset left", left_o, 0);
    check("R1 reset right", right_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {15'd0, valid_o, left_o}, 0);

    sweep(2'd2, "R3 left-justified");
    sweep(2'd1, "R4 i2s-style");
    sweep(2'd0, "R5 right-justified");
    sweep(2'd3, "R3 mode3");

    // R8: mode changes mid frame with same polarity; frame decodes in old mode
    mode_i = 2'd2;
    send_frame(2'd2, 16'h1234, 16'hFEDC, "R3 pre-switch");
    send_slot(2'd2, 1'b1, 16'h3C5A);
    mode_i = 2'd0;
    expect_pair("R8 old mode kept", 16'h3C5A, 16'hC3A5);
    send_slot(2'd2, 1'b0, 16'hC3A5);
    send_frame(2'd0, 16'h0F0F, 16'hF0F0, "R8 new mode active");

    // R9: stranded left word dropped when polarity flips
    mode_i = 2'd1;
    prime(2'd1);
    send_frame(2'd1, 16'h7E81, 16'h8118, "R4 before drop");
    send_slot(2'd1, 1'b0, 16'hDEAD);
    mode_i = 2'd2;
    send_frame(2'd2, 16'hBEEF, 16'h0420, "R9 after drop");

    repeat (100) @(negedge clk);
    check("R9 strobe count", n_got, n_exp);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule